// File: doc/BRIEF.md
# Ring Slot Relay Node

This block is one node in a ring of full-duplex character links that carry 9-bit characters. Every character received is passed on to the output one clock later. The ninth bit of a character works as a slot marker. A node that is armed treats the first marked character it sees, together with the characters that follow it, as its own slot of `N_BYTES` characters. The default is 12.

The node keeps the low eight bits of each slot character in a capture buffer. On the output it puts its own replacement bytes in their place, with the ninth bit cleared. Marked characters after the slot pass through unchanged, so the marker reaches the next node one slot further along.

Nodes need no address and no configuration. A ring of any length organises itself, and each node holds a fixed position in the frame. A node serves one slot per frame. After serving it, the node re-arms only when the receive stream has been idle for `IDLE_CYCLES` consecutive clocks, which is the gap between frames. Receive and transmit run at the same time: a new character can enter on the same clock that the previous one leaves. The UART serializers on both sides are outside this block. Characters arrive as one-clock strobes.

Top module: `ring_slot_node`

## Requirements
- R1: Every received character that is not part of this node's slot appears on the output with all nine bits unchanged.
- R2: Each character strobed in on `rx_valid_i` appears on `tx_valid_o`/`tx_data_o` exactly one clock later. `tx_valid_o` is high only in those cycles, and back-to-back characters leave back-to-back.
- R3: While armed, the first received character with bit 8 set starts the slot. That character is slot index 0, and the next `N_BYTES-1` received characters are indices 1 to `N_BYTES-1`. Unmarked characters seen while armed do not start a slot and do not disarm the node.
- R4: Slot character k leaves as `{1'b0, repl_i[8k+7:8k]}`. Marked characters after the slot leave with bit 8 still set, so the marker moves one slot downstream.
- R5: `repl_i` is latched on the clock edge that takes in slot index 0. Changes to `repl_i` after that edge do not alter the bytes sent in that slot.
- R6: `cap_o[8k+7:8k]` holds bits 7:0 of slot character k. `cap_valid_o` is low from the cycle after slot index 0 is taken in. It goes high in the cycle after the last slot character and stays high until the next slot starts.
- R7: After a slot completes, marked characters are forwarded unchanged until the receive stream has been idle for `IDLE_CYCLES` consecutive clocks. A gap of `IDLE_CYCLES-1` clocks does not re-arm the node.
- R8: An idle gap of `IDLE_CYCLES` clocks during a slot abandons that slot and re-arms the node. `cap_valid_o` stays low, and the next marked character starts a fresh slot at index 0.
- R9: After reset the node is armed and `tx_valid_o`, `cap_valid_o` and `cap_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-clock strobe: a received character is present |
| rx_data_i | input | 9 | Received character; bit 8 is the slot marker |
| repl_i | input | N_BYTES*8 | Replacement payload; byte k in bits 8k+7:8k |
| tx_valid_o | output | 1 | One-clock strobe: an outgoing character is present |
| tx_data_o | output | 9 | Outgoing character |
| cap_o | output | N_BYTES*8 | Captured payload; byte k in bits 8k+7:8k |
| cap_valid_o | output | 1 | High when a complete slot has been captured |

## Verification
Every outgoing character is due one clock after its input strobe. The bench drives a character before an edge and reads `tx_data_o` at the falling edge that follows, so it compares each character in the single cycle the character is valid. `cap_valid_o` and `cap_o` are read at that same falling edge after slot index 0 and after the last slot character, where they must already be low and high respectively. Re-arming is checked by idle gaps of exactly `IDLE_CYCLES-1` and exactly `IDLE_CYCLES` clocks, and the next marked character then shows whether replacement took place.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  localparam int unsigned CHAR_W = 9;
  localparam int unsigned BYTE_W = 8;
  typedef logic [CHAR_W-1:0] char_t;

  function automatic logic is_marked(char_t c);
    return c[CHAR_W-1];
  endfunction
endpackage

// File: rtl/ring_slot_ctrl.sv
module ring_slot_ctrl #(
  parameter int unsigned N_BYTES     = 12,
  parameter int unsigned IDLE_CYCLES = 16,
  localparam int unsigned IDX_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1,
  localparam int unsigned CNT_W = $clog2(IDLE_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic             marked_i,
  output logic             slot_start_o,
  output logic             slot_act_o,
  output logic             slot_last_o,
  output logic [IDX_W-1:0] slot_idx_o
);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] IDLE_SAT  = CNT_W'(IDLE_CYCLES);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(N_BYTES - 1);

  logic             armed_q, in_slot_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] idle_q;
  logic             idle_hit;

  always_comb begin
    slot_start_o = rx_valid_i && armed_q && marked_i && !in_slot_q;
    slot_act_o   = rx_valid_i && (slot_start_o || in_slot_q);
    slot_idx_o   = slot_start_o ? '0 : idx_q;
    slot_last_o  = slot_act_o && (slot_idx_o == IDX_LAST);
    idle_hit     = !rx_valid_i && (idle_q == IDLE_LAST);
  end

  // idle gap counter saturates; it re-arms once per gap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
    end else if (rx_valid_i) begin
      idle_q <= '0;
    end else if (idle_q != IDLE_SAT) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b1;
      in_slot_q <= 1'b0;
      idx_q     <= '0;
    end else if (idle_hit) begin
      armed_q   <= 1'b1;
      in_slot_q <= 1'b0;
      idx_q     <= '0;
    end else if (slot_act_o) begin
      if (slot_start_o) armed_q <= 1'b0;
      in_slot_q <= !slot_last_o;
      idx_q     <= slot_last_o ? '0 : slot_idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/ring_capture_buf.sv
module ring_capture_buf
  import ring_node_pkg::*;
#(
  parameter int unsigned N_BYTES = 12,
  localparam int unsigned IDX_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [BYTE_W-1:0]       byte_i,
  input  logic                    start_i,
  input  logic                    last_i,
  output logic [N_BYTES*8-1:0]    cap_o,
  output logic                    cap_valid_o
);
  for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             byte_q <= '0;
      else if (wr_i && idx_i == IDX_W'(k))     byte_q <= byte_i;
    end
    assign cap_o[k*8 +: 8] = byte_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cap_valid_o <= 1'b0;
    else if (wr_i && last_i)    cap_valid_o <= 1'b1;
    else if (start_i)           cap_valid_o <= 1'b0;
  end
endmodule

// File: rtl/ring_tx_mux.sv
module ring_tx_mux
  import ring_node_pkg::*;
#(
  parameter int unsigned N_BYTES = 12,
  localparam int unsigned IDX_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_valid_i,
  input  char_t                rx_data_i,
  input  logic [N_BYTES*8-1:0] repl_i,
  input  logic                 start_i,
  input  logic                 act_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic                 tx_valid_o,
  output char_t                tx_data_o
);
  logic [N_BYTES*8-1:0] repl_q, src;
  logic [BYTE_W-1:0]    sub;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       repl_q <= '0;
    else if (start_i)  repl_q <= repl_i;
  end

  // slot index 0 reads the live input, later indices the latched copy
  always_comb begin
    src = start_i ? repl_i : repl_q;
    sub = src[{idx_i, 3'b000} +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= rx_valid_i;
      if (rx_valid_i) tx_data_o <= act_i ? {1'b0, sub} : rx_data_i;
    end
  end
endmodule

// File: rtl/ring_slot_node.sv
module ring_slot_node
  import ring_node_pkg::*;
#(
  parameter int unsigned N_BYTES     = 12,
  parameter int unsigned IDLE_CYCLES = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_valid_i,
  input  logic [8:0]           rx_data_i,
  input  logic [N_BYTES*8-1:0] repl_i,
  output logic                 tx_valid_o,
  output logic [8:0]           tx_data_o,
  output logic [N_BYTES*8-1:0] cap_o,
  output logic                 cap_valid_o
);
  localparam int unsigned IDX_W = (N_BYTES > 1) ? $clog2(N_BYTES) : 1;

  logic             slot_start, slot_act, slot_last;
  logic [IDX_W-1:0] slot_idx;

  ring_slot_ctrl #(.N_BYTES(N_BYTES), .IDLE_CYCLES(IDLE_CYCLES)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_valid_i   (rx_valid_i),
    .marked_i     (is_marked(rx_data_i)),
    .slot_start_o (slot_start),
    .slot_act_o   (slot_act),
    .slot_last_o  (slot_last),
    .slot_idx_o   (slot_idx)
  );

  ring_capture_buf #(.N_BYTES(N_BYTES)) i_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (slot_act),
    .idx_i       (slot_idx),
    .byte_i      (rx_data_i[7:0]),
    .start_i     (slot_start),
    .last_i      (slot_last),
    .cap_o       (cap_o),
    .cap_valid_o (cap_valid_o)
  );

  ring_tx_mux #(.N_BYTES(N_BYTES)) i_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .repl_i     (repl_i),
    .start_i    (slot_start),
    .act_i      (slot_act),
    .idx_i      (slot_idx),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o)
  );
endmodule

// File: rtl/ring_slot_node_chk.sv
module ring_slot_node_chk #(
  parameter int unsigned N_BYTES = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rx_valid_i,
  input logic [8:0]           rx_data_i,
  input logic                 tx_valid_o,
  input logic [8:0]           tx_data_o,
  input logic [N_BYTES*8-1:0] cap_o,
  input logic                 cap_valid_o
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> tx_valid_o);

  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !tx_valid_o);

  a_r4_marked_forwarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_data_o[8]) |-> (tx_data_o == $past(rx_data_i)));

  a_r6_flag_moves_on_char: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(cap_valid_o));

  a_r6_cap_moves_on_char: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(cap_o));
endmodule

bind ring_slot_node ring_slot_node_chk #(.N_BYTES(N_BYTES)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .rx_data_i   (rx_data_i),
  .tx_valid_o  (tx_valid_o),
  .tx_data_o   (tx_data_o),
  .cap_o       (cap_o),
  .cap_valid_o (cap_valid_o)
);

// File: tb/test_ring_slot_node.sv
`timescale 1ns/1ps
module test_ring_slot_node;
  localparam int BN   = 4;
  localparam int IDLE = 6;
  localparam int LEN  = 9;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            rx_valid_i = 1'b0;
  logic [8:0]      rx_data_i = '0;
  logic [BN*8-1:0] repl_i = '0;
  logic            tx_valid_o;
  logic [8:0]      tx_data_o;
  logic [BN*8-1:0] cap_o;
  logic            cap_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [BN*8-1:0] exp_cap;

  always #10 clk_i = ~clk_i;

  ring_slot_node #(.N_BYTES(BN), .IDLE_CYCLES(IDLE)) i_ring_slot_node (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dat_b(int f, int j);
    return 8'(f * 37 + j * 5 + 3);
  endfunction

  function automatic logic [7:0] rep_b(int f, int k);
    return 8'(f * 11 + k * 29 + 128);
  endfunction

  // drive one char, check it on the falling edge after the capturing edge
  task automatic send(input logic [8:0] d, input logic [8:0] e, input string req);
    rx_valid_i = 1'b1;
    rx_data_i  = d;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(tx_valid_o === 1'b1 && tx_data_o === e, req, {tx_valid_o, tx_data_o}, {1'b1, e});
    rx_valid_i = 1'b0;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (i == 0) chk(tx_valid_o === 1'b0, "R2 idle", tx_valid_o, 0);
    end
  endtask

  // frame of LEN chars, marker set from index m on; slot served if take
  task automatic frame(input int f, input int m, input bit take);
    for (int k = 0; k < BN; k++) repl_i[k*8 +: 8] = rep_b(f, k);
    for (int j = 0; j < LEN; j++) begin
      logic [8:0] d;
      logic [8:0] e;
      bit in_s;
      d = {j >= m, dat_b(f, j)};
      in_s = take && j >= m && j < m + BN;
      e = in_s ? {1'b0, rep_b(f, j - m)} : d;
      if (in_s) exp_cap[(j - m)*8 +: 8] = dat_b(f, j);
      send(d, e, in_s ? "R4 slot replace" : (j >= m ? "R7/R4 marked forward" : "R1 echo"));
      if (in_s && j == m) begin
        repl_i = ~repl_i; // R5: late change must not matter
        if (BN > 1) chk(cap_valid_o === 1'b0, "R6 flag cleared", cap_valid_o, 0);
      end
      if (in_s && j == m + BN - 1) begin
        chk(cap_valid_o === 1'b1, "R6 flag set", cap_valid_o, 1);
        chk(cap_o === exp_cap, "R6 capture", cap_o, exp_cap);
      end
    end
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk_i);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk_i);
    chk(tx_valid_o === 1'b0 && cap_valid_o === 1'b0 && cap_o === '0, "R9 reset",
        {tx_valid_o, cap_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3: a frame with no marker keeps the node armed
    frame(0, LEN, 1'b0);
    gap(1);
    frame(1, 2, 1'b1);
    gap(IDLE);

    // sweep of marker positions, R3/R4/R5/R6
    for (int m = 0; m <= LEN - BN; m++) begin
      frame(10 + m, m, 1'b1);
      gap(IDLE + (m % 3));
    end

    // R7: gap one short of the limit leaves the node disarmed
    frame(30, 1, 1'b1);
    gap(IDLE - 1);
    frame(31, 0, 1'b0);
    chk(cap_valid_o === 1'b1, "R7 flag held", cap_valid_o, 1);
    gap(IDLE);
    frame(32, 3, 1'b1);
    // R7: back-to-back frame without gap is forwarded
    frame(33, 0, 1'b0);
    gap(IDLE);

    // R8: idle gap mid-slot aborts and re-arms
    for (int k = 0; k < BN; k++) repl_i[k*8 +: 8] = rep_b(40, k);
    send({1'b1, dat_b(40, 0)}, {1'b0, rep_b(40, 0)}, "R8 slot begin");
    send({1'b1, dat_b(40, 1)}, {1'b0, rep_b(40, 1)}, "R8 slot second");
    gap(IDLE);
    chk(cap_valid_o === 1'b0, "R8 flag low after abort", cap_valid_o, 0);
    frame(41, 0, 1'b1);
    gap(IDLE);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule